// File: doc/BRIEF.md
# Sprite Attribute Snoop Cache

This block keeps a private copy of the leading half of every sprite attribute record: the vertical position word and the size/link word of each of 80 sprites. It never fetches anything from video memory. Instead it watches the byte-wide video-memory write bus. When a write lands inside the attribute table window, and on one of the cached byte offsets of a record, the block stores that byte. The window starts at a table-base address supplied by a register elsewhere.

Each record occupies 8 bytes in memory, and the first 4 of them are cached. Moving the table base only moves the snoop window. Nothing is reloaded, and bytes captured from the old location stay readable until later snooped writes replace them. The sprite-evaluation logic reads one 16-bit field of one sprite per cycle through a registered read port. That rate easily covers a walk through the list at two cycles per sprite.

Top module: `sprite_attr_cache`

## Requirements
- R1: After reset, every field of every sprite reads as 0x0000.
- R2: A write whose offset from `table_base` (modulo 2^16) is below 640 and whose offset bits [2:0] are 0 to 3 stores `snoop_data` as byte (offset bits [1:0]) of sprite (offset bits [9:3]). Field 0 reads as {byte0, byte1} and field 1 reads as {byte2, byte3}.
- R3: Writes whose offset bits [2:0] are 4 to 7 change no cached byte.
- R4: Writes whose offset is 640 or more change no cached byte.
- R5: A write replaces exactly one byte. The other byte of the same field keeps its value.
- R6: Changing `table_base` reloads nothing. Earlier contents stay readable, writes to the old location are ignored, and writes in the new window are stored.
- R7: A read and a write to the same sprite in the same cycle both complete. The read returns the value before the write, and the next read returns the new value.
- R8: `rd_data` shows the addressed field one cycle after `rd_en` is sampled high, and holds its value while `rd_en` is low, even across writes.
- R9: The offset wraps modulo 2^16, so a window that starts near the top of memory continues at address 0.
- R10: Sprite 79 (offsets 632 to 635) is stored like any other sprite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snoop_we | input | 1 | Video-memory byte write strobe |
| snoop_addr | input | 16 | Byte address of the snooped write |
| snoop_data | input | 8 | Byte value of the snooped write |
| table_base | input | 16 | Current start address of the attribute table |
| rd_en | input | 1 | Read request from sprite evaluation |
| rd_index | input | 7 | Sprite number, 0 to 79 |
| rd_field | input | 1 | 0 selects vertical position, 1 selects size/link |
| rd_data | output | 16 | Registered field value |

## Verification
A snooped write and an evaluation read can fall on the same cycle. The bench provokes this by driving a write to one byte of a sprite together with a read of the field that contains that byte, both on the same edge. It judges the result by requiring the pre-write value in that read and the new byte in the following read. It also checks that a write made while `rd_en` is low leaves `rd_data` untouched.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int unsigned SAC_ADDR_W      = 16;
  localparam int unsigned SAC_NUM_SPRITES = 80;
  localparam int unsigned SAC_REC_BYTES   = 8;
  localparam int unsigned SAC_KEPT_BYTES  = 4;

  typedef enum logic {
    FLD_VPOS      = 1'b0,
    FLD_SIZE_LINK = 1'b1
  } sac_field_e;
endpackage

// File: rtl/sac_snoop_decode.sv
module sac_snoop_decode #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned NUM_SPRITES = 80,
  parameter int unsigned REC_BYTES   = 8,
  parameter int unsigned KEPT_BYTES  = 4,
  parameter int unsigned IDX_W       = 7,
  parameter int unsigned LANE_W      = 2
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] lane
);
  localparam int unsigned REC_W  = $clog2(REC_BYTES);
  localparam int unsigned WINDOW = NUM_SPRITES * REC_BYTES;

  logic [ADDR_W-1:0] ofs;
  logic              in_window;
  logic              in_kept;

  always_comb begin
    ofs       = addr - base;
    in_window = ofs < ADDR_W'(WINDOW);
    in_kept   = ofs[REC_W-1:0] < REC_W'(KEPT_BYTES);
    hit       = strobe && in_window && in_kept;
    idx       = ofs[REC_W +: IDX_W];
    lane      = ofs[LANE_W-1:0];
  end

  // R10: a hit never addresses a sprite beyond the table
  always_comb begin
    if (hit) begin
      a_r10_index_range: assert (int'(idx) < int'(NUM_SPRITES));
    end
  end
endmodule

// File: rtl/sac_lane_ram.sv
module sac_lane_ram #(
  parameter int unsigned DEPTH = 80,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rbyte
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [7:0]       q;
  logic             qv;

  // storage array without reset, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

  // per-byte presence flags give the all-zero state after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      qv  <= 1'b0;
    end else begin
      if (re) qv <= vld[raddr];
      if (we) vld[waddr] <= 1'b1;
    end
  end

  assign rbyte = qv ? q : 8'h00;

  // R2: a stored byte is marked present on the next cycle
  a_r2_write_marks_present: assert property (@(posedge clk) disable iff (rst)
    we |=> vld[$past(waddr)]);

  // R6: nothing but a snooped write alters the contents
  a_r6_no_reload_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(vld));
endmodule

// File: rtl/sprite_attr_cache.sv
module sprite_attr_cache
  import sac_pkg::*;
#(
  parameter int unsigned ADDR_W      = SAC_ADDR_W,
  parameter int unsigned NUM_SPRITES = SAC_NUM_SPRITES,
  parameter int unsigned REC_BYTES   = SAC_REC_BYTES,
  parameter int unsigned KEPT_BYTES  = SAC_KEPT_BYTES,
  localparam int unsigned IDX_W      = $clog2(NUM_SPRITES),
  localparam int unsigned LANE_W     = $clog2(KEPT_BYTES),
  localparam int unsigned FSEL_W     = LANE_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_we,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [7:0]        snoop_data,
  input  logic [ADDR_W-1:0] table_base,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_index,
  input  logic [FSEL_W-1:0] rd_field,
  output logic [15:0]       rd_data
);
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [LANE_W-1:0] hit_lane;
  logic [7:0]        lane_q [KEPT_BYTES];
  logic [FSEL_W-1:0] fld_q;

  sac_snoop_decode #(
    .ADDR_W(ADDR_W), .NUM_SPRITES(NUM_SPRITES), .REC_BYTES(REC_BYTES),
    .KEPT_BYTES(KEPT_BYTES), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) decode_i (
    .strobe(snoop_we), .addr(snoop_addr), .base(table_base),
    .hit(hit), .idx(hit_idx), .lane(hit_lane)
  );

  for (genvar l = 0; l < KEPT_BYTES; l++) begin : g_lane
    sac_lane_ram #(.DEPTH(NUM_SPRITES), .IDX_W(IDX_W)) ram_i (
      .clk(clk), .rst(rst),
      .we(hit && (hit_lane == LANE_W'(l))),
      .waddr(hit_idx), .wdata(snoop_data),
      .re(rd_en), .raddr(rd_index),
      .rbyte(lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) fld_q <= '0;
    else if (rd_en) fld_q <= rd_field;
  end

  // big-endian field: lower byte address is the high half
  assign rd_data = {lane_q[{fld_q, 1'b0}], lane_q[{fld_q, 1'b1}]};

  // R8: output holds while no read is requested
  a_r8_hold_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sprite_attr_cache_tb_top.sv
module sprite_attr_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snoop_we = 1'b0;
  logic [15:0] snoop_addr = '0;
  logic [7:0]  snoop_data = '0;
  logic [15:0] table_base = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_index = '0;
  logic [0:0]  rd_field = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sprite_attr_cache dut_i (
    .clk(clk), .rst(rst), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
    .snoop_data(snoop_data), .table_base(table_base), .rd_en(rd_en),
    .rd_index(rd_index), .rd_field(rd_field), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    snoop_we = 1'b1; snoop_addr = a; snoop_data = d;
    @(negedge clk);
    snoop_we = 1'b0;
  endtask

  task automatic read_field(input int idx, input bit f, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_index = 7'(idx); rd_field = f;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    bit bad = 1'b0;
    logic [15:0] first_bad = '0;
    for (int i = 0; i < 80; i++) begin
      for (int f = 0; f < 2; f++) begin
        read_field(i, f[0], v);
        if (v !== 16'h0000 && !bad) begin bad = 1'b1; first_bad = v; end
      end
    end
    check("R1 all fields zero after reset", first_bad, 16'h0000);
  endtask

  task automatic t_basic_store();
    logic [15:0] v;
    table_base = 16'h1000;
    snoop(16'h1000, 8'h12); snoop(16'h1001, 8'h34);
    snoop(16'h1002, 8'h56); snoop(16'h1003, 8'h78);
    read_field(0, 1'b0, v); check("R2 sprite0 vpos", v, 16'h1234);
    read_field(0, 1'b1, v); check("R2 sprite0 size/link", v, 16'h5678);
    snoop(16'h1278, 8'hA1); snoop(16'h1279, 8'hA2);
    snoop(16'h127A, 8'hA3); snoop(16'h127B, 8'hA4);
    read_field(79, 1'b0, v); check("R10 sprite79 vpos", v, 16'hA1A2);
    read_field(79, 1'b1, v); check("R10 sprite79 size/link", v, 16'hA3A4);
  endtask

  task automatic t_upper_half_ignored();
    logic [15:0] v;
    snoop(16'h1004, 8'hAA);
    snoop(16'h100D, 8'hBB);
    read_field(0, 1'b0, v); check("R3 offset 4 ignored", v, 16'h1234);
    read_field(1, 1'b0, v); check("R3 offset 13 ignored", v, 16'h0000);
  endtask

  task automatic t_outside_ignored();
    logic [15:0] v;
    snoop(16'h1400, 8'hEE);
    snoop(16'h1282, 8'hEF);
    snoop(16'h0FF8, 8'hED);
    read_field(0, 1'b0, v); check("R4 offset 1024 ignored", v, 16'h1234);
    read_field(0, 1'b1, v); check("R4 offsets 642/below base ignored", v, 16'h5678);
  endtask

  task automatic t_single_byte();
    logic [15:0] v;
    snoop(16'h1001, 8'h99);
    read_field(0, 1'b0, v); check("R5 low byte replaced, high kept", v, 16'h1299);
  endtask

  task automatic t_base_move();
    logic [15:0] v;
    @(negedge clk); table_base = 16'h2000;
    read_field(0, 1'b0, v); check("R6 old vpos kept after base move", v, 16'h1299);
    snoop(16'h1002, 8'h11);
    read_field(0, 1'b1, v); check("R6 old location ignored", v, 16'h5678);
    snoop(16'h202A, 8'hAB);
    read_field(5, 1'b1, v); check("R6 new window stored", v, 16'hAB00);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    @(negedge clk);
    snoop_we = 1'b1; snoop_addr = 16'h202B; snoop_data = 8'hCD;
    rd_en = 1'b1; rd_index = 7'd5; rd_field = 1'b1;
    @(negedge clk);
    snoop_we = 1'b0; rd_en = 1'b0;
    check("R7 same-cycle read sees old value", rd_data, 16'hAB00);
    read_field(5, 1'b1, v); check("R7 following read sees write", v, 16'hABCD);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    read_field(5, 1'b1, v);
    snoop(16'h202A, 8'h00);
    @(negedge clk);
    check("R8 output held while idle", rd_data, 16'hABCD);
    read_field(5, 1'b1, v); check("R8 one-cycle read latency", v, 16'h00CD);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    @(negedge clk); table_base = 16'hFF00;
    snoop(16'h0010, 8'h42);
    read_field(34, 1'b0, v); check("R9 window wraps past top", v, 16'h4200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_basic_store();
    t_upper_half_ignored();
    t_outside_ignored();
    t_single_byte();
    t_base_move();
    t_same_cycle();
    t_hold();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule